// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block is the controller-side state machine that takes a set of DDR3 ranks from cold reset to a state where they accept normal traffic. Once `init_en` is seen, it holds the memory reset low for a fixed interval. It then releases reset and waits again before raising CKE. After a short settling delay it issues mode-register writes to the targeted chip selects. Each chip select gets a DLL relock pause after its writes. The run ends with two long ZQ calibration commands. Every interval is given in nanoseconds and turned into clock cycles from the clock period parameter.

The mode-register contents are built from static configuration inputs: burst control, CAS latency, write recovery, precharge power-down mode, CAS write latency, dynamic and nominal on-die termination, driver impedance and the multi-purpose register fields. These inputs must not change while the sequence runs. Commands leave on a one-cycle command interface of operation, chip select, bank and address. The NOP operation is driven whenever no command is issued. `done` rises once the last command gap has expired and stays high until reset.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, `mem_rst_n`, `cke` and `done` are 0 and `cmd_op` is NOP (0). `cke` is never high while `mem_rst_n` is low.
- R2: On the clock edge that samples `init_en` high in the idle state, counting starts. `mem_rst_n` rises exactly RST_CYC = ceil(T_RST_NS*1000/CLK_PS) cycles after that edge, and `cke` is still low at that point.
- R3: `cke` rises CKE_CYC cycles after `mem_rst_n` rises. The first command appears XPR_CYC cycles after `cke` rises. No command is issued while `cke` is low.
- R4: Each command is valid for a single cycle. For one chip select, MRS commands (`cmd_op`=1) go to banks 2, 3, 1 and 0 in that order, each MRD_CYC+1 cycles after the one before it.
- R5: The MR0 address (bank 0) is built as follows: bits 1:0 carry `burst_ctl`, bit 2 carries `cas_lat[0]`, bit 3 is 1, bits 6:4 carry `cas_lat[3:1]`, bit 7 is 0, bit 8 is 1 (DLL reset), bits 11:9 carry `wr_rec` and bit 12 carries `pd_slow`.
- R6: The MR2 address (bank 2) is built as follows: bits 5:3 carry `cas_wlat`, bit 6 is 1, bit 7 is 0, bits 10:9 carry `odt_wr`, and all other bits are 0.
- R7: The MR3 address (bank 3) is built as follows: bits 1:0 carry `mpr_loc`, bit 2 carries `mpr_en`, and all other bits are 0.
- R8: The MR1 address (bank 1) is built as follows: `drv_imp[1]` goes to bit 5 and `drv_imp[0]` to bit 1. `odt_nom` bits 2, 1 and 0 go to address bits 9, 6 and 2. All other bits are 0. When `four_dimm` is 1 and the chip select is odd, the three termination bits are 0.
- R9: After the MR0 write of a chip select, the next command follows MRD_CYC+1+DLL_CYC cycles later.
- R10: With `registered`=0, only the lowest present chip select is initialised. With `registered`=1, every present chip select is initialised in ascending order. Absent chip selects receive no command.
- R11: After the last chip select, two ZQCL commands follow (`cmd_op`=2, bank 0, address bit 10 set). They go first to the even and then to the odd chip select of the pair that holds the lowest present chip select, ZQ_CYC+1 cycles apart. `done` rises ZQ_CYC+1 cycles after the second one and stays high.
- R12: When no chip select is present, no command is issued and `done` rises at the point where the first command would have been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_en | input | 1 | Starts the sequence from idle |
| cs_present | input | NUM_CS | One bit per populated chip select |
| registered | input | 1 | 1 = registered DIMMs, walk every present rank |
| four_dimm | input | 1 | Four-DIMM-per-channel configuration |
| burst_ctl | input | 2 | Burst length control for MR0 |
| cas_lat | input | 4 | Encoded CAS latency for MR0 |
| wr_rec | input | 3 | Encoded write recovery for MR0 |
| pd_slow | input | 1 | Precharge power-down mode select for MR0 |
| cas_wlat | input | 3 | Encoded CAS write latency for MR2 |
| odt_wr | input | 2 | Dynamic write termination for MR2 |
| drv_imp | input | 2 | Output driver impedance for MR1 |
| odt_nom | input | 3 | Nominal termination for MR1 |
| mpr_loc | input | 2 | Multi-purpose register location for MR3 |
| mpr_en | input | 1 | Multi-purpose register enable for MR3 |
| mem_rst_n | output | 1 | Memory reset, active low |
| cke | output | 1 | Clock enable |
| cmd_op | output | 2 | 0 NOP, 1 MRS, 2 ZQCL |
| cmd_cs | output | $clog2(NUM_CS) | Target chip select of the command |
| cmd_bank | output | 3 | Bank address of the command |
| cmd_addr | output | 13 | Address bits A12:A0 of the command |
| done | output | 1 | Sequence complete |

## Verification
The bench builds the block with CLK_PS=5000, four chip selects, and reset, CKE, settle and DLL intervals shortened to 20, 30, 4 and 12 cycles, with MRD_CYC=4 and ZQ_CYC=6. These short waits make a full sweep affordable: all sixteen presence masks, under both DIMM kinds and both values of the four-DIMM flag. The sweep covers the empty and the single-rank cases, odd first ranks that move the ZQ pair, and the odd-rank termination override. Every command is checked for operation, target, bank, address and its exact cycle, against a timeline the bench builds from the interval arithmetic.

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq #(
  parameter int CLK_PS   = 2500,
  parameter int NUM_CS   = 4,
  parameter int T_RST_NS = 200000,
  parameter int T_CKE_NS = 500000,
  parameter int T_XPR_NS = 360,
  parameter int T_DLL_NS = 500000,
  parameter int MRD_CYC  = 4,
  parameter int ZQ_CYC   = 512
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      init_en,
  input  logic [NUM_CS-1:0]         cs_present,
  input  logic                      registered,
  input  logic                      four_dimm,
  input  logic [1:0]                burst_ctl,
  input  logic [3:0]                cas_lat,
  input  logic [2:0]                wr_rec,
  input  logic                      pd_slow,
  input  logic [2:0]                cas_wlat,
  input  logic [1:0]                odt_wr,
  input  logic [1:0]                drv_imp,
  input  logic [2:0]                odt_nom,
  input  logic [1:0]                mpr_loc,
  input  logic                      mpr_en,
  output logic                      mem_rst_n,
  output logic                      cke,
  output logic [1:0]                cmd_op,
  output logic [$clog2(NUM_CS)-1:0] cmd_cs,
  output logic [2:0]                cmd_bank,
  output logic [12:0]               cmd_addr,
  output logic                      done
);
  localparam int CS_W    = $clog2(NUM_CS);
  localparam int RST_CYC = (T_RST_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CKE_CYC = (T_CKE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int XPR_CYC = (T_XPR_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int DLL_CYC = (T_DLL_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int MAX_A   = (RST_CYC > CKE_CYC) ? RST_CYC : CKE_CYC;
  localparam int MAX_B   = (DLL_CYC > ZQ_CYC) ? DLL_CYC : ZQ_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > XPR_CYC) ? ((MAX_C > MRD_CYC) ? MAX_C : MRD_CYC) : XPR_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_CKE, S_XPR, S_CMD, S_GAP, S_DLL, S_DONE} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        mr_idx;
  logic              zq_ph, zq_sel;
  logic [CS_W-1:0]   cur_cs, first_cs, first_idx, nxt_idx;
  logic              first_hit, nxt_hit;
  logic [2:0]        rtt_eff;
  logic [2:0]        mr_bank;
  logic [12:0]       mr_val;

  always_comb begin
    first_hit = 1'b0;
    first_idx = '0;
    nxt_hit   = 1'b0;
    nxt_idx   = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (cs_present[i]) begin
        first_hit = 1'b1;
        first_idx = CS_W'(i);
      end
      if (cs_present[i] && (i > int'(cur_cs))) begin
        nxt_hit = 1'b1;
        nxt_idx = CS_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      mem_rst_n <= 1'b0;
      cke       <= 1'b0;
      mr_idx    <= '0;
      zq_ph     <= 1'b0;
      zq_sel    <= 1'b0;
      cur_cs    <= '0;
      first_cs  <= '0;
    end else begin
      case (state)
        S_IDLE: if (init_en) begin
          state <= S_RST;
          cnt   <= CNT_W'(RST_CYC - 1);
        end
        S_RST: if (cnt == '0) begin
          mem_rst_n <= 1'b1;
          state     <= S_CKE;
          cnt       <= CNT_W'(CKE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_CKE: if (cnt == '0) begin
          cke   <= 1'b1;
          state <= S_XPR;
          cnt   <= CNT_W'(XPR_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_XPR: if (cnt == '0) begin
          if (first_hit) begin
            cur_cs   <= first_idx;
            first_cs <= first_idx;
            mr_idx   <= '0;
            state    <= S_CMD;
          end else state <= S_DONE;
        end else cnt <= cnt - 1'b1;
        S_CMD: begin
          state <= S_GAP;
          cnt   <= zq_ph ? CNT_W'(ZQ_CYC - 1) : CNT_W'(MRD_CYC - 1);
        end
        S_GAP: if (cnt == '0) begin
          if (zq_ph) begin
            if (zq_sel) state <= S_DONE;
            else begin
              zq_sel <= 1'b1;
              state  <= S_CMD;
            end
          end else if (mr_idx == 2'd3) begin
            state <= S_DLL;
            cnt   <= CNT_W'(DLL_CYC - 1);
          end else begin
            mr_idx <= mr_idx + 2'd1;
            state  <= S_CMD;
          end
        end else cnt <= cnt - 1'b1;
        S_DLL: if (cnt == '0) begin
          mr_idx <= '0;
          state  <= S_CMD;
          if (registered && nxt_hit) cur_cs <= nxt_idx;
          else begin
            zq_ph  <= 1'b1;
            zq_sel <= 1'b0;
          end
        end else cnt <= cnt - 1'b1;
        default: state <= S_DONE;
      endcase
    end
  end

  assign rtt_eff = (four_dimm && cur_cs[0]) ? 3'b000 : odt_nom;
  assign mr_bank = {1'b0, ~mr_idx[1], mr_idx[1] ^ mr_idx[0]};

  always_comb begin
    mr_val = '0;
    case (mr_idx)
      2'd0: mr_val = {2'b00, odt_wr, 2'b00, 1'b1, cas_wlat, 3'b000};
      2'd1: mr_val = {10'd0, mpr_en, mpr_loc};
      2'd2: begin
        mr_val[9] = rtt_eff[2];
        mr_val[6] = rtt_eff[1];
        mr_val[2] = rtt_eff[0];
        mr_val[5] = drv_imp[1];
        mr_val[1] = drv_imp[0];
      end
      default: mr_val = {pd_slow, wr_rec, 1'b1, 1'b0, cas_lat[3:1], 1'b1, cas_lat[0], burst_ctl};
    endcase
  end

  wire issuing = (state == S_CMD);
  assign cmd_op   = issuing ? (zq_ph ? 2'd2 : 2'd1) : 2'd0;
  assign cmd_cs   = zq_ph ? ((first_cs & ~CS_W'(1)) | CS_W'(zq_sel)) : cur_cs;
  assign cmd_bank = (issuing && !zq_ph) ? mr_bank : 3'd0;
  assign cmd_addr = !issuing ? 13'd0 : (zq_ph ? 13'h0400 : mr_val);
  assign done     = (state == S_DONE);

  // R1
  cke_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n) cke |-> mem_rst_n);
  // R2
  rst_first_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_rst_n) |-> !cke);
  // R3
  cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n) (cmd_op != 2'd0) |-> (cke && mem_rst_n));
  // R4
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) (cmd_op != 2'd0) |=> (cmd_op == 2'd0));
  // R5
  mr0_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd1 && cmd_bank == 3'd0) |-> (cmd_addr[8] && cmd_addr[3] && !cmd_addr[7]));
  // R8
  odd_rtt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd1 && cmd_bank == 3'd1 && four_dimm && cmd_cs[0]) |-> (cmd_addr[9] == 1'b0 && cmd_addr[6] == 1'b0 && cmd_addr[2] == 1'b0));
  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> done);
endmodule

// File: tb/ddr3_pwrup_seq_tb.sv
`timescale 1ns/1ps
module ddr3_pwrup_seq_tb_top;
  localparam int NCS  = 4;
  localparam int CLKP = 5000;
  localparam int TR = 100, TC = 150, TX = 20, TD = 60;
  localparam int MRD = 4, ZQ = 6;
  localparam int RSTC = (TR * 1000 + CLKP - 1) / CLKP;
  localparam int CKEC = (TC * 1000 + CLKP - 1) / CLKP;
  localparam int XPRC = (TX * 1000 + CLKP - 1) / CLKP;
  localparam int DLLC = (TD * 1000 + CLKP - 1) / CLKP;

  logic clk = 1'b0, rst_n = 1'b0, init_en = 1'b0;
  logic [NCS-1:0] cs_present = '0;
  logic registered = 1'b0, four_dimm = 1'b0;
  logic [1:0] burst_ctl = '0, odt_wr = '0, drv_imp = '0, mpr_loc = '0;
  logic [3:0] cas_lat = '0;
  logic [2:0] wr_rec = '0, cas_wlat = '0, odt_nom = '0;
  logic pd_slow = 1'b0, mpr_en = 1'b0;
  logic mem_rst_n, cke, done;
  logic [1:0] cmd_op;
  logic [1:0] cmd_cs;
  logic [2:0] cmd_bank;
  logic [12:0] cmd_addr;

  int cyc = 0;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr3_pwrup_seq #(.CLK_PS(CLKP), .NUM_CS(NCS), .T_RST_NS(TR), .T_CKE_NS(TC),
                   .T_XPR_NS(TX), .T_DLL_NS(TD), .MRD_CYC(MRD), .ZQ_CYC(ZQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_en(init_en), .cs_present(cs_present),
    .registered(registered), .four_dimm(four_dimm), .burst_ctl(burst_ctl),
    .cas_lat(cas_lat), .wr_rec(wr_rec), .pd_slow(pd_slow), .cas_wlat(cas_wlat),
    .odt_wr(odt_wr), .drv_imp(drv_imp), .odt_nom(odt_nom), .mpr_loc(mpr_loc),
    .mpr_en(mpr_en), .mem_rst_n(mem_rst_n), .cke(cke), .cmd_op(cmd_op),
    .cmd_cs(cmd_cs), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .done(done));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  int e_op[32], e_cs[32], e_bank[32], e_addr[32], e_t[32];
  int g_op[32], g_cs[32], g_bank[32], g_addr[32], g_t[32];

  task automatic run_one(input int r);
    int e_n, g_n, first, t0, t, t_rst, t_cke, t_done, lim, rtt;
    cs_present = NCS'(r & 15);
    registered = r[4];
    four_dimm  = r[5];
    burst_ctl  = 2'(r % 4);
    cas_lat    = 4'((r * 3) % 16);
    wr_rec     = 3'((r * 5) % 8);
    pd_slow    = r[0] ^ r[1];
    cas_wlat   = 3'((r * 7) % 8);
    odt_wr     = 2'((r >> 1) % 4);
    drv_imp    = 2'((r + 1) % 4);
    odt_nom    = 3'((r * 3 + 1) % 8);
    mpr_loc    = 2'((r + 2) % 4);
    mpr_en     = r[2];
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {mem_rst_n, cke, done, cmd_op}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    init_en = 1'b1;
    t0 = cyc + 1;
    g_n = 0; t_rst = -1; t_cke = -1; t_done = -1; lim = 0;
    while (t_done < 0 && lim < 4000) begin
      @(negedge clk);
      init_en = 1'b0;
      lim++;
      if (mem_rst_n && t_rst < 0) t_rst = cyc;
      if (cke && t_cke < 0) t_cke = cyc;
      if (done) t_done = cyc;
      if (cmd_op != 2'd0 && g_n < 32) begin
        g_op[g_n] = int'(cmd_op); g_cs[g_n] = int'(cmd_cs); g_bank[g_n] = int'(cmd_bank);
        g_addr[g_n] = int'(cmd_addr); g_t[g_n] = cyc; g_n++;
      end
    end
    if (t_done < 0) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: run %0d actual no done expected done", r);
    end
    // expected timeline
    e_n = 0; first = -1;
    for (int i = 0; i < NCS; i++) if (cs_present[i] && first < 0) first = i;
    t = t0 + RSTC + CKEC + XPRC;
    for (int i = 0; i < NCS; i++) begin
      if (cs_present[i] && (registered || i == first)) begin
        for (int k = 0; k < 4; k++) begin
          e_op[e_n] = 1; e_cs[e_n] = i; e_t[e_n] = t;
          case (k)
            0: begin e_bank[e_n] = 2; e_addr[e_n] = (int'(cas_wlat) << 3) | 64 | (int'(odt_wr) << 9); end
            1: begin e_bank[e_n] = 3; e_addr[e_n] = int'(mpr_loc) | (int'(mpr_en) << 2); end
            2: begin
              e_bank[e_n] = 1;
              rtt = (four_dimm && (i % 2 == 1)) ? 0 : int'(odt_nom);
              e_addr[e_n] = (((rtt >> 2) & 1) << 9) | (((rtt >> 1) & 1) << 6) | ((rtt & 1) << 2)
                          | ((int'(drv_imp) >> 1) << 5) | ((int'(drv_imp) & 1) << 1);
            end
            default: begin
              e_bank[e_n] = 0;
              e_addr[e_n] = int'(burst_ctl) | ((int'(cas_lat) & 1) << 2) | 8 | ((int'(cas_lat) >> 1) << 4)
                          | 256 | (int'(wr_rec) << 9) | (int'(pd_slow) << 12);
            end
          endcase
          e_n++;
          t = t + MRD + 1 + ((k == 3) ? DLLC : 0);
        end
      end
    end
    if (first >= 0) begin
      for (int z = 0; z < 2; z++) begin
        e_op[e_n] = 2; e_cs[e_n] = (first & ~1) | z; e_bank[e_n] = 0; e_addr[e_n] = 1024; e_t[e_n] = t;
        e_n++;
        t = t + ZQ + 1;
      end
    end
    chk("R2 reset release cycle", t_rst, t0 + RSTC);
    chk("R3 cke rise cycle", t_cke, t0 + RSTC + CKEC);
    chk("R10 command count", g_n, e_n);
    if (first < 0) chk("R12 done without commands", t_done, t);
    else chk("R11 done cycle", t_done, t);
    for (int j = 0; j < e_n && j < g_n; j++) begin
      chk("R4 R10 op/cs/bank order", (g_op[j] << 8) | (g_cs[j] << 4) | g_bank[j],
          (e_op[j] << 8) | (e_cs[j] << 4) | e_bank[j]);
      chk("R4 R9 R11 command cycle", g_t[j], e_t[j]);
      if (e_op[j] == 2) chk("R11 ZQCL address", g_addr[j], e_addr[j]);
      else if (e_bank[j] == 0) chk("R5 MR0 value", g_addr[j], e_addr[j]);
      else if (e_bank[j] == 1) chk("R8 MR1 value", g_addr[j], e_addr[j]);
      else if (e_bank[j] == 2) chk("R6 MR2 value", g_addr[j], e_addr[j]);
      else chk("R7 MR3 value", g_addr[j], e_addr[j]);
    end
    repeat (2) @(negedge clk);
    chk("R11 done holds", int'(done), 1);
  endtask

  initial begin
    for (int r = 0; r < 64; r++) run_one(r);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(190000 * 5);
    n_chk++; n_bad++;
    $display("FAIL R11 global watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule